// File: doc/BRIEF.md
# Double-Precision Compare, Min/Max and Sign-Injection Unit

This unit takes two 64-bit binary64 operands and a 3-bit opcode and produces either a one-bit comparison result or a 64-bit value, together with an invalid-operation flag. The three comparisons (equal, less-than, less-or-equal) follow IEEE ordering rather than integer ordering. Positive and negative zero are equal. Infinities of one sign are equal. Any NaN makes the operands unordered. Minimum and maximum step around a single NaN operand, and they order negative zero below positive zero. The three sign-injection operations rewrite only the sign bit.

The datapath is combinational. It sits between a valid/ready request channel and a valid/ready result channel. With `REG_OUT=1` (the default) one register stage is placed on the result side. A request is accepted in a cycle where `in_valid` and `in_ready` are both high, and its result appears on the next cycle. `in_ready` is high whenever the output stage is empty or the consumer is taking its contents (`out_ready`). While `out_valid` is high and `out_ready` is low, the result and flag are held unchanged. With `REG_OUT=0` the channels are wired straight through: `in_ready` follows `out_ready`, and `out_valid` follows `in_valid`.

Top module: `fp64_cmpsel`

## Requirements
- R1: Opcode 0 (equal), 1 (less-than) and 2 (less-or-equal) place their answer in bit 0 of `out_result` and clear bits 63..1. For ordered operands, equal values give 1, 0, 1 respectively, and a < b gives 0, 1, 1.
- R2: Positive and negative zero compare equal in either order, so less-than between them is 0. Two infinities of the same sign compare equal.
- R3: Opcode 3 (minimum) returns the smaller operand and opcode 4 (maximum) returns the larger one. When exactly one operand is NaN (exponent all ones, fraction non-zero), both return the other operand unchanged.
- R4: When both operands of minimum or maximum are NaN, the result is 0x7ff8000000000000.
- R5: Minimum of +0 and -0 is -0 (0x8000000000000000) in either operand order. Maximum of the same pair is +0 (0x0000000000000000).
- R6: Opcodes 5, 6 and 7 return bits 62..0 of a unchanged. Bit 63 is set to b's sign (opcode 5), to the inverse of b's sign (opcode 6), or to the XOR of both signs (opcode 7). These opcodes never raise the invalid flag, and NaN payloads pass through intact.
- R7: A signaling NaN has fraction bit 51 clear. Equal raises `out_invalid` only if an operand is a signaling NaN. Less-than and less-or-equal raise it for any NaN operand and return 0. Minimum and maximum raise it only for a signaling NaN operand.
- R8: With `REG_OUT=1`, an accepted request appears on the result channel one cycle later. `in_ready` equals `!out_valid || out_ready`. A stalled result (`out_valid` high, `out_ready` low) keeps its value and flag.
- R9: While `rst_n` is low and after it is released, `out_valid` is 0 until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 3 | Operation select (0..7) |
| in_a | input | 64 | Operand a |
| in_b | input | 64 | Operand b |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | Comparison bit or 64-bit value |
| out_invalid | output | 1 | Invalid-operation flag for this result |

## Verification
The datapath assertions take for granted that `in_op`, `in_a` and `in_b` carry known values in every cycle where `in_valid` is high. The stall assertion assumes `out_ready` is driven to a known level in every cycle after reset. The stimulus meets both conditions: it drives all inputs from time zero, and it sets them only between clock edges, including during idle gaps and stalls. The operands are drawn from signed zeros, infinities, quiet and signaling NaNs of both signs, subnormals and random bit patterns. Each value is paired with itself as well as with others, so the equal, unordered and zero-ordering corners are all reached under random back-pressure.

// File: rtl/fp64_cmpsel_pkg.sv
package fp64_cmpsel_pkg;

  typedef enum logic [2:0] {
    OP_EQ    = 3'd0,
    OP_LT    = 3'd1,
    OP_LE    = 3'd2,
    OP_MIN   = 3'd3,
    OP_MAX   = 3'd4,
    OP_SGNJ  = 3'd5,
    OP_SGNJN = 3'd6,
    OP_SGNJX = 3'd7
  } op_e;

  // Operand classification shared by the ordering and selection stages
  typedef struct packed {
    logic sign;
    logic is_zero;
    logic is_nan;
    logic is_snan;
  } cls_t;

endpackage

// File: rtl/fp64_cmpsel_classify.sv
module fp64_cmpsel_classify
  import fp64_cmpsel_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] val,
  output cls_t         cls
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;
  logic              exp_none;
  logic              frac_none;

  assign exp_f     = val[W-2 -: EXP_W];
  assign frac_f    = val[FRAC_W-1:0];
  assign exp_ones  = &exp_f;
  assign exp_none  = ~|exp_f;
  assign frac_none = ~|frac_f;

  always_comb begin
    cls.sign    = val[W-1];
    cls.is_zero = exp_none & frac_none;
    cls.is_nan  = exp_ones & ~frac_none;
    cls.is_snan = exp_ones & ~frac_none & ~frac_f[FRAC_W-1];
  end

endmodule

// File: rtl/fp64_cmpsel_order.sv
module fp64_cmpsel_order
  import fp64_cmpsel_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  cls_t         ca,
  input  cls_t         cb,
  output logic         eq,
  output logic         lt,
  output logic         lt_tot
);

  logic mag_lt;
  logic mag_gt;
  logic unord;
  logic both_zero;

  // Magnitudes of binary64 values order like unsigned integers
  assign mag_lt    = a[W-2:0] < b[W-2:0];
  assign mag_gt    = a[W-2:0] > b[W-2:0];
  assign unord     = ca.is_nan | cb.is_nan;
  assign both_zero = ca.is_zero & cb.is_zero;

  always_comb begin
    eq = ~unord & ((a == b) | both_zero);
    lt = 1'b0;
    if (!unord && !both_zero) begin
      if (ca.sign) lt = ~cb.sign | mag_gt;
      else         lt = ~cb.sign & mag_lt;
    end
    // Total order used by min/max: -0 sorts below +0
    lt_tot = lt | (both_zero & ca.sign & ~cb.sign);
  end

endmodule

// File: rtl/fp64_cmpsel_select.sv
module fp64_cmpsel_select
  import fp64_cmpsel_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  cls_t         ca,
  input  cls_t         cb,
  input  logic         eq,
  input  logic         lt,
  input  logic         lt_tot,
  output logic [W-1:0] res,
  output logic         inv
);

  localparam logic [W-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic any_nan;
  logic any_snan;
  op_e  opc;

  assign any_nan  = ca.is_nan | cb.is_nan;
  assign any_snan = ca.is_snan | cb.is_snan;
  assign opc      = op_e'(op);

  always_comb begin
    res = '0;
    inv = 1'b0;
    unique case (opc)
      OP_EQ: begin
        res[0] = eq;
        inv    = any_snan;
      end
      OP_LT: begin
        res[0] = lt;
        inv    = any_nan;
      end
      OP_LE: begin
        res[0] = lt | eq;
        inv    = any_nan;
      end
      OP_MIN, OP_MAX: begin
        inv = any_snan;
        if (ca.is_nan && cb.is_nan) res = CANON_NAN;
        else if (ca.is_nan)         res = b;
        else if (cb.is_nan)         res = a;
        else if ((opc == OP_MIN) == lt_tot) res = a;
        else                        res = b;
      end
      OP_SGNJ:  res = {cb.sign, a[W-2:0]};
      OP_SGNJN: res = {~cb.sign, a[W-2:0]};
      OP_SGNJX: res = {ca.sign ^ cb.sign, a[W-2:0]};
      default:  res = '0;
    endcase
  end

endmodule

// File: rtl/fp64_cmpsel_outstage.sv
module fp64_cmpsel_outstage #(
  parameter int DW      = 65,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  generate
    if (REG_OUT) begin : g_reg
      logic          vld_q;
      logic [DW-1:0] data_q;

      assign in_ready  = ~vld_q | out_ready;
      assign out_valid = vld_q;
      assign out_data  = data_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
        end else if (in_ready) begin
          vld_q <= in_valid;
        end
      end

      always_ff @(posedge clk) begin
        if (in_ready && in_valid) data_q <= in_data;
      end

      AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
      AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R8
      AST_RESET_IDLE: assert property (@(posedge clk)
        $rose(rst_n) |-> !out_valid); // R9
    end else begin : g_pass
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate

endmodule

// File: rtl/fp64_cmpsel.sv
module fp64_cmpsel
  import fp64_cmpsel_pkg::*;
#(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter bit REG_OUT = 1'b1,
  localparam int W      = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [2:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_invalid
);

  localparam logic [W-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [W-1:0] opnd [2];
  cls_t         cls  [2];
  logic         eq, lt, lt_tot;
  logic [W-1:0] core_res;
  logic         core_inv;
  logic [W:0]   out_bus;

  assign opnd[0] = in_a;
  assign opnd[1] = in_b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fp64_cmpsel_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .val (opnd[i]),
      .cls (cls[i])
    );
  end

  fp64_cmpsel_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_order (
    .a      (in_a),
    .b      (in_b),
    .ca     (cls[0]),
    .cb     (cls[1]),
    .eq     (eq),
    .lt     (lt),
    .lt_tot (lt_tot)
  );

  fp64_cmpsel_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_select (
    .op     (in_op),
    .a      (in_a),
    .b      (in_b),
    .ca     (cls[0]),
    .cb     (cls[1]),
    .eq     (eq),
    .lt     (lt),
    .lt_tot (lt_tot),
    .res    (core_res),
    .inv    (core_inv)
  );

  fp64_cmpsel_outstage #(.DW(W + 1), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({core_inv, core_res}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_bus)
  );

  assign out_result  = out_bus[W-1:0];
  assign out_invalid = out_bus[W];

  AST_CMP_BIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op <= 3'd2 |-> core_res[W-1:1] == '0); // R1
  AST_LT_EQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !(lt && eq)); // R1
  AST_ZERO_PAIR_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cls[0].is_zero && cls[1].is_zero |-> eq && !lt); // R2
  AST_NAN_UNORD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (cls[0].is_nan || cls[1].is_nan) |-> !eq && !lt); // R7
  AST_DUAL_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_op == 3'd3 || in_op == 3'd4) && cls[0].is_nan && cls[1].is_nan
    |-> core_res == CANON_NAN); // R4
  AST_SGN_BODY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op >= 3'd5 |-> core_res[W-2:0] == in_a[W-2:0] && !core_inv); // R6

endmodule

// File: tb/fp64_cmpsel_bench.sv
module fp64_cmpsel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = 3'd0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_invalid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit bp_rand = 1'b0;

  always #(HALF) clk = ~clk;

  fp64_cmpsel u_fp64_cmpsel (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_invalid(out_invalid)
  );

  function automatic bit is_nan(logic [63:0] x);
    return (x[62:52] == 11'h7ff) && (x[51:0] != 0);
  endfunction

  function automatic bit is_snan(logic [63:0] x);
    return is_nan(x) && !x[51];
  endfunction

  function automatic bit is_zero(logic [63:0] x);
    return x[62:0] == 0;
  endfunction

  // Behavioural expectation built on real-number comparison
  task automatic expect_of(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                           output logic [63:0] r, output bit inv,
                           output string tag, output string ftag);
    real ra, rb;
    bit  un;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    un = is_nan(a) || is_nan(b);
    r = 64'd0;
    inv = 1'b0;
    if (op <= 3'd2) begin
      if (un) tag = "R7";
      else if ((is_zero(a) && is_zero(b)) || a[62:52] == 11'h7ff || b[62:52] == 11'h7ff) tag = "R2";
      else tag = "R1";
      ftag = "R7";
      if (op == 3'd0) begin
        inv = is_snan(a) || is_snan(b);
        r[0] = !un && (ra == rb);
      end else begin
        inv = un;
        r[0] = !un && ((op == 3'd1) ? (ra < rb) : (ra <= rb));
      end
    end else if (op <= 3'd4) begin
      ftag = "R7";
      inv = is_snan(a) || is_snan(b);
      if (is_nan(a) && is_nan(b)) begin tag = "R4"; r = 64'h7ff8000000000000; end
      else if (is_nan(a)) begin tag = "R3"; r = b; end
      else if (is_nan(b)) begin tag = "R3"; r = a; end
      else if (is_zero(a) && is_zero(b)) begin
        tag = "R5";
        if (op == 3'd3) r = (a[63] ? a : b);
        else            r = (a[63] ? b : a);
      end else begin
        tag = "R3";
        if (op == 3'd3) r = (rb < ra) ? b : a;
        else            r = (rb > ra) ? b : a;
      end
    end else begin
      tag = "R6";
      ftag = "R6";
      r = a;
      if (op == 3'd5)      r[63] = b[63];
      else if (op == 3'd6) r[63] = !b[63];
      else                 r[63] = a[63] ^ b[63];
    end
  endtask

  // Cycle model of the result register
  logic        m_vld = 1'b0;
  logic [2:0]  m_op;
  logic [63:0] m_a, m_b;

  always @(posedge clk) begin
    if (!rst_n) m_vld <= 1'b0;
    else if (!m_vld || out_ready) begin
      m_vld <= in_valid;
      if (in_valid) begin
        m_op <= in_op; m_a <= in_a; m_b <= in_b;
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) begin
        checks++;
        if (out_valid !== 1'b0) begin
          errors++;
          $display("FAIL R9 out_valid in reset act=%b exp=0", out_valid);
        end
      end else begin
        logic [63:0] er;
        bit          ei;
        string       tg, ft;
        checks++;
        if (out_valid !== m_vld) begin
          errors++;
          $display("FAIL R8 out_valid act=%b exp=%b", out_valid, m_vld);
        end
        checks++;
        if (in_ready !== (!m_vld || out_ready)) begin
          errors++;
          $display("FAIL R8 in_ready act=%b exp=%b", in_ready, (!m_vld || out_ready));
        end
        if (m_vld) begin
          expect_of(m_op, m_a, m_b, er, ei, tg, ft);
          checks++;
          if (out_result !== er) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h result act=%h exp=%h", tg, m_op, m_a, m_b, out_result, er);
          end
          checks++;
          if (out_invalid !== ei) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h invalid act=%b exp=%b", ft, m_op, m_a, m_b, out_invalid, ei);
          end
        end
      end
    end
  end

  // Back-pressure driver
  always @(negedge clk) begin
    #1;
    if (bp_rand) out_ready = ($urandom % 10) < 6;
    else         out_ready = 1'b1;
  end

  task automatic send(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
    bit acc;
    @(negedge clk); #1;
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    acc = 1'b0;
    while (!acc) begin
      #(HALF - 2);
      acc = in_ready;
      @(negedge clk); #1;
    end
    in_valid = 1'b0;
  endtask

  function automatic logic [63:0] pick();
    case ($urandom % 16)
      0:  return 64'h0000000000000000;
      1:  return 64'h8000000000000000;
      2:  return 64'h7ff0000000000000;
      3:  return 64'hfff0000000000000;
      4:  return 64'h7ff8000000000000;
      5:  return 64'hfff8000000000123;
      6:  return 64'h7ff0000000000001;
      7:  return 64'hfff4000000000000;
      8:  return 64'h000fffffffffffff;
      9:  return 64'h800fffffffffffff;
      10: return $realtobits(1.0);
      11: return $realtobits(-1.36);
      default: return {$urandom, $urandom};
    endcase
  endfunction

  localparam logic [63:0] PZ = 64'h0, NZ = 64'h8000000000000000;
  localparam logic [63:0] PINF = 64'h7ff0000000000000, NINF = 64'hfff0000000000000;
  localparam logic [63:0] QN = 64'h7ff8000000000000, SN = 64'h7ff0000000000001;

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    // R1 ordinary compares
    send(3'd0, $realtobits(-1.36), $realtobits(-1.36));
    send(3'd1, $realtobits(-1.36), $realtobits(-1.36));
    send(3'd2, $realtobits(-1.36), $realtobits(-1.36));
    send(3'd0, $realtobits(-1.37), $realtobits(-1.36));
    send(3'd1, $realtobits(-1.37), $realtobits(-1.36));
    send(3'd2, $realtobits(-1.37), $realtobits(-1.36));
    // R2 zeros and infinities
    send(3'd0, PZ, NZ); send(3'd1, NZ, PZ); send(3'd2, PZ, NZ);
    send(3'd0, NINF, NINF); send(3'd1, NINF, NINF); send(3'd0, PINF, NINF);
    // R3 min/max with one NaN
    send(3'd3, QN, $realtobits(-1235.1)); send(3'd4, QN, $realtobits(-1235.1));
    send(3'd3, $realtobits(2.5), $realtobits(1.0)); send(3'd4, $realtobits(-1.0), $realtobits(-2.0));
    send(3'd3, SN, $realtobits(3.0));
    // R4 both NaN
    send(3'd3, QN, SN); send(3'd4, 64'hfff8000000000001, QN);
    // R5 signed zeros
    send(3'd3, PZ, NZ); send(3'd3, NZ, PZ); send(3'd4, PZ, NZ); send(3'd4, NZ, PZ);
    // R6 sign injection
    send(3'd5, $realtobits(6.3), $realtobits(-1.0));
    send(3'd6, $realtobits(-8.3), $realtobits(-3.0));
    send(3'd7, $realtobits(-9.3), $realtobits(4.0));
    send(3'd7, SN, NZ);
    // R7 flags
    send(3'd0, QN, QN); send(3'd0, SN, PZ); send(3'd1, QN, PZ); send(3'd2, PZ, QN);
    // R8 random traffic with back-pressure and idle gaps
    bp_rand = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a, b;
      a = pick();
      b = ($urandom % 5 == 0) ? a : pick();
      send(3'($urandom % 8), a, b);
      if ($urandom % 4 == 0) @(negedge clk);
    end
    bp_rand = 1'b0;
    repeat (6) @(negedge clk);
    #2;
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL R8 watchdog act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule